// File: doc/BRIEF.md
# ADC Conversion Accumulation Controller

This block is the digital side of an analog-to-digital converter. It decides when the converter core runs, sums a programmable power-of-two number of consecutive samples into a result, and keeps the newest raw sample in its own register. A control byte selects free-running restart, left-adjusted presentation and the accumulation depth. A separate immediate-start command launches work. A result-ready flag announces each finished accumulation and stays set until software clears it or reads the result.

The converter is driven through a single-cycle start pulse. It answers with a single-cycle done pulse that carries a 12-bit sample. A sequencer with three states controls that exchange. `SEQ_IDLE` waits for the start command (transition *go*). `SEQ_LAUNCH` issues the start pulse and always moves on to `SEQ_WAIT` (transition *issue*). In `SEQ_WAIT` a done pulse either relaunches for the next sample of the same accumulation (transition *next*), relaunches a new accumulation in free-running mode (transition *rerun*), or returns to idle after the last sample (transition *finish*).

Top module: `adc_accum_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, the ready flag is 0, the sequencer is idle, no start pulse is issued, and the result and sample outputs are 0.
- R2: The control byte uses bit 5 for free-running enable, bit 4 for left adjust and bits 2:0 for the depth code. Bits 7:6 and bit 3 always read 0, whatever value is written to them.
- R3: Depth codes 0 to 6 select 1, 2, 4, 8, 16, 32 and 64 samples. Code 7 selects 64 samples. The code is captured when an accumulation begins.
- R4: The result is the 18-bit sum of exactly the selected number of consecutive samples. The ready flag is set on the clock edge that accepts the last sample's done pulse, and at no other time.
- R5: After every accepted done pulse, the sample output holds that pulse's raw data, including samples that are not the last of an accumulation.
- R6: Setting free-running enable starts no conversion. The first start pulse follows only the start command.
- R7: With free-running enabled, a new accumulation is launched right after each completed one, and its start pulse comes in the cycle after the ready flag is set.
- R8: With left adjust set, the sample output is the 12-bit sample shifted left by 4. The result output is shifted left by 4 minus the depth exponent when that exponent is at most 4, and is left unshifted otherwise. With left adjust clear, both are right-aligned.
- R9: Clearing free-running enable lets the accumulation in progress complete, and then no further start pulse is issued.
- R10: Either a write-one clear or a result read clears the ready flag. If a completion happens in the same cycle as a clear, the flag is set.
- R11: Each start pulse lasts one cycle. No new start pulse is issued until the done pulse for the previous one arrives, and a start command while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the control byte |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_q | output | 8 | Control byte read value |
| go_cmd | input | 1 | Immediate-start command strobe |
| rdy_clr | input | 1 | Write-one clear of the ready flag |
| res_rd | input | 1 | Result read strobe; clears the ready flag |
| conv_start | output | 1 | One-cycle start pulse to the converter core |
| conv_done | input | 1 | One-cycle done pulse from the converter core |
| conv_data | input | 12 | Sample data, valid with conv_done |
| busy | output | 1 | Sequencer is not idle |
| res_rdy | output | 1 | Result-ready flag |
| res_data | output | 18 | Accumulated result, optionally left-adjusted |
| smp_data | output | 16 | Latest raw sample, optionally left-adjusted |

## Verification
Properties checked on every cycle:
- the start handshake: single-cycle pulses, no second start before a done, and no start from idle without the command;
- the control byte write mask;
- the ready flag, which may rise only on a done pulse and must fall after a clear when no completion coincides.

Only the directed scenarios can show:
- the arithmetic of the sums and the code-7 clamp;
- the left-adjust shift amounts;
- that free-running keeps relaunching, and that it stops cleanly after the bit is cleared mid-run.

// File: rtl/adc_acc_pkg.sv
package adc_acc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LAUNCH = 2'd1,
        SEQ_WAIT   = 2'd2
    } seq_state_t;

    localparam int BIT_FREERUN = 5;
    localparam int BIT_LADJ    = 4;
    localparam int CODE_W      = 3;
    localparam logic [7:0] CFG_MASK = 8'h37;

endpackage

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg
    import adc_acc_pkg::*;
#(
    parameter int MAX_LOG2 = 6,
    parameter int NSEL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [7:0]        wdata,
    output logic [7:0]        cfg_q,
    output logic              freerun,
    output logic              ladj,
    output logic [NSEL_W-1:0] n_sel
);

    logic [7:0]        cfg_r;
    logic [CODE_W-1:0] code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_r <= '0;
        end else if (we) begin
            cfg_r <= wdata & CFG_MASK;
        end
    end

    assign cfg_q   = cfg_r;
    assign freerun = cfg_r[BIT_FREERUN];
    assign ladj    = cfg_r[BIT_LADJ];
    assign code    = cfg_r[CODE_W-1:0];

    // reserved codes fold onto the deepest accumulation
    always_comb begin
        if (int'(code) > MAX_LOG2) begin
            n_sel = NSEL_W'(MAX_LOG2);
        end else begin
            n_sel = NSEL_W'(code);
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_acc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_cmd,
    input  logic freerun,
    input  logic conv_done,
    input  logic last_smp,
    output logic conv_start,
    output logic busy,
    output logic acc_start,
    output logic smp_take
);

    seq_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_IDLE: begin
                if (go_cmd) nxt = SEQ_LAUNCH;              // go
            end
            SEQ_LAUNCH: begin
                nxt = SEQ_WAIT;                            // issue
            end
            SEQ_WAIT: begin
                if (conv_done) begin
                    if (!last_smp)    nxt = SEQ_LAUNCH;    // next
                    else if (freerun) nxt = SEQ_LAUNCH;    // rerun
                    else              nxt = SEQ_IDLE;      // finish
                end
            end
            default: nxt = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        conv_start = (state == SEQ_LAUNCH);
        busy       = (state != SEQ_IDLE);
        smp_take   = (state == SEQ_WAIT) && conv_done;
        acc_start  = ((state == SEQ_IDLE) && go_cmd)
                   || (smp_take && last_smp && freerun);
    end

endmodule

// File: rtl/adc_accum.sv
module adc_accum #(
    parameter int SMP_W    = 12,
    parameter int MAX_LOG2 = 6,
    parameter int NSEL_W   = 3,
    parameter int RES_W    = SMP_W + MAX_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_start,
    input  logic [NSEL_W-1:0] n_sel,
    input  logic              smp_take,
    input  logic [SMP_W-1:0]  smp_in,
    output logic              last_smp,
    output logic              acc_done,
    output logic [RES_W-1:0]  res_q,
    output logic [NSEL_W-1:0] res_n,
    output logic [SMP_W-1:0]  smp_q
);

    localparam int CNT_W = MAX_LOG2 + 1;

    logic [RES_W-1:0]  acc_r;
    logic [CNT_W-1:0]  cnt_r;
    logic [NSEL_W-1:0] n_lat;
    logic [CNT_W-1:0]  cnt_last;
    logic [RES_W-1:0]  sum;

    assign cnt_last = CNT_W'((1 << n_lat) - 1);
    assign last_smp = (cnt_r == cnt_last);
    assign acc_done = smp_take && last_smp;
    assign sum      = ((cnt_r == '0) ? '0 : acc_r) + RES_W'(smp_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_r <= '0;
            cnt_r <= '0;
            n_lat <= '0;
            res_q <= '0;
            res_n <= '0;
            smp_q <= '0;
        end else begin
            if (acc_start) begin
                cnt_r <= '0;
                n_lat <= n_sel;
            end
            if (smp_take) begin
                smp_q <= smp_in;
                if (last_smp) begin
                    res_q <= sum;
                    res_n <= n_lat;
                    cnt_r <= '0;
                end else begin
                    acc_r <= sum;
                    cnt_r <= cnt_r + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/adc_align.sv
module adc_align #(
    parameter int SMP_W  = 12,
    parameter int OUT_W  = 16,
    parameter int RES_W  = 18,
    parameter int NSEL_W = 3
) (
    input  logic              ladj,
    input  logic [RES_W-1:0]  res_i,
    input  logic [NSEL_W-1:0] res_n,
    input  logic [SMP_W-1:0]  smp_i,
    output logic [RES_W-1:0]  res_o,
    output logic [OUT_W-1:0]  smp_o
);

    localparam int HEAD = OUT_W - SMP_W;

    always_comb begin
        res_o = res_i;
        if (ladj && (int'(res_n) <= HEAD)) begin
            res_o = res_i << (HEAD - int'(res_n));
        end
    end

    always_comb begin
        smp_o = OUT_W'(smp_i);
        if (ladj) begin
            smp_o = OUT_W'(smp_i) << HEAD;
        end
    end

endmodule

// File: rtl/adc_accum_ctrl.sv
module adc_accum_ctrl
    import adc_acc_pkg::*;
#(
    parameter int SMP_W    = 12,
    parameter int MAX_LOG2 = 6,
    parameter int OUT_W    = 16,
    parameter int RES_W    = SMP_W + MAX_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_q,
    input  logic             go_cmd,
    input  logic             rdy_clr,
    input  logic             res_rd,
    output logic             conv_start,
    input  logic             conv_done,
    input  logic [SMP_W-1:0] conv_data,
    output logic             busy,
    output logic             res_rdy,
    output logic [RES_W-1:0] res_data,
    output logic [OUT_W-1:0] smp_data
);

    localparam int NSEL_W = $clog2(MAX_LOG2 + 1);

    logic              freerun, ladj;
    logic [NSEL_W-1:0] n_sel, res_n;
    logic              last_smp, acc_start, smp_take, acc_done;
    logic [RES_W-1:0]  res_q;
    logic [SMP_W-1:0]  smp_q;
    logic              rdy_r;

    adc_cfg_reg #(.MAX_LOG2(MAX_LOG2), .NSEL_W(NSEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .cfg_q(cfg_q), .freerun(freerun), .ladj(ladj), .n_sel(n_sel)
    );

    adc_seq_fsm u_seq (
        .clk(clk), .rst_n(rst_n), .go_cmd(go_cmd), .freerun(freerun),
        .conv_done(conv_done), .last_smp(last_smp), .conv_start(conv_start),
        .busy(busy), .acc_start(acc_start), .smp_take(smp_take)
    );

    adc_accum #(.SMP_W(SMP_W), .MAX_LOG2(MAX_LOG2), .NSEL_W(NSEL_W), .RES_W(RES_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .n_sel(n_sel),
        .smp_take(smp_take), .smp_in(conv_data), .last_smp(last_smp),
        .acc_done(acc_done), .res_q(res_q), .res_n(res_n), .smp_q(smp_q)
    );

    adc_align #(.SMP_W(SMP_W), .OUT_W(OUT_W), .RES_W(RES_W), .NSEL_W(NSEL_W)) u_align (
        .ladj(ladj), .res_i(res_q), .res_n(res_n), .smp_i(smp_q),
        .res_o(res_data), .smp_o(smp_data)
    );

    // completion has priority over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_r <= 1'b0;
        end else if (acc_done) begin
            rdy_r <= 1'b1;
        end else if (rdy_clr || res_rd) begin
            rdy_r <= 1'b0;
        end
    end

    assign res_rdy = rdy_r;

endmodule

// File: rtl/adc_accum_ctrl_chk.sv
module adc_accum_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_q,
    input logic       go_cmd,
    input logic       rdy_clr,
    input logic       res_rd,
    input logic       conv_start,
    input logic       conv_done,
    input logic       busy,
    input logic       res_rdy
);

    logic pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pending <= 1'b0;
        else if (conv_start) pending <= 1'b1;
        else if (conv_done)  pending <= 1'b0;
    end

    // R11
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R11
    start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !pending);

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go_cmd) |=> !conv_start);

    // R2
    cfg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == ($past(cfg_wdata) & 8'h37)));

    // R4
    rdy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_rdy) |-> $past(conv_done));

    // R10
    rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_rdy && (rdy_clr || res_rd) && !conv_done) |=> !res_rdy);

endmodule

bind adc_accum_ctrl adc_accum_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .go_cmd(go_cmd), .rdy_clr(rdy_clr), .res_rd(res_rd),
    .conv_start(conv_start), .conv_done(conv_done), .busy(busy),
    .res_rdy(res_rdy)
);

// File: tb/adc_accum_ctrl_bench.sv
`timescale 1ns/1ps
module adc_accum_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_q;
    logic        go_cmd = 1'b0;
    logic        rdy_clr = 1'b0;
    logic        res_rd = 1'b0;
    logic        conv_start;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic        busy;
    logic        res_rdy;
    logic [17:0] res_data;
    logic [15:0] smp_data;

    int total = 0;
    int bad = 0;
    int n_starts = 0;
    int k = 0;
    int d_base = 0;
    int d_step = 0;

    always #4 clk = ~clk;

    adc_accum_ctrl u_adc_accum_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .go_cmd(go_cmd), .rdy_clr(rdy_clr), .res_rd(res_rd),
        .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
        .busy(busy), .res_rdy(res_rdy), .res_data(res_data), .smp_data(smp_data)
    );

    // converter core model: two cycles of latency per conversion
    initial begin
        forever begin
            @(negedge clk);
            while (conv_start) begin
                n_starts++;
                repeat (2) @(negedge clk);
                conv_data = 12'(d_base + d_step * k);
                k++;
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_go();
        @(negedge clk); go_cmd = 1'b1;
        @(negedge clk); go_cmd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); rdy_clr = 1'b1;
        @(negedge clk); rdy_clr = 1'b0;
    endtask

    task automatic wait_rdy(input string tag);
        int t = 0;
        while (!res_rdy && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check({tag, " ready seen"}, res_rdy, 1);
    endtask

    task automatic prep(input int base, input int step);
        @(negedge clk);
        d_base = base; d_step = step; k = 0; n_starts = 0;
    endtask

    task automatic t_reset();
        check("R1 cfg", cfg_q, 0);
        check("R1 rdy", res_rdy, 0);
        check("R1 busy", busy, 0);
        check("R1 start", conv_start, 0);
        check("R1 res", res_data, 0);
        check("R1 smp", smp_data, 0);
    endtask

    task automatic t_cfg_mask();
        write_cfg(8'hFF);
        check("R2 mask", cfg_q, 8'h37);
        write_cfg(8'h00);
        check("R2 zero", cfg_q, 0);
    endtask

    task automatic t_single();
        prep(12'h5A5, 0);
        pulse_go();
        wait_rdy("R4 single");
        check("R3 single res", res_data, 12'h5A5);
        check("R5 single smp", smp_data, 12'h5A5);
        repeat (10) @(negedge clk);
        check("R11 single starts", n_starts, 1);
        check("R4 single idle", busy, 0);
        pulse_clr();
    endtask

    task automatic t_accum4();
        write_cfg(8'h02);
        prep(100, 100);
        pulse_go();
        wait_rdy("R4 acc4");
        check("R4 acc4 res", res_data, 1000);
        check("R5 acc4 smp", smp_data, 400);
        check("R3 acc4 starts", n_starts, 4);
    endtask

    task automatic t_left_adj();
        write_cfg(8'h12);
        check("R8 acc4 res shifted", res_data, 4000);
        check("R8 smp shifted", smp_data, 400 << 4);
        write_cfg(8'h02);
        check("R8 res plain", res_data, 1000);
        pulse_clr();
        write_cfg(8'h15);
        prep(1, 0);
        pulse_go();
        wait_rdy("R8 acc32");
        check("R8 acc32 unshifted", res_data, 32);
        check("R3 acc32 starts", n_starts, 32);
        pulse_clr();
    endtask

    task automatic t_reserved();
        write_cfg(8'h07);
        prep(4095, 0);
        pulse_go();
        wait_rdy("R3 code7");
        check("R3 code7 res", res_data, 64 * 4095);
        check("R3 code7 starts", n_starts, 64);
        pulse_clr();
    endtask

    task automatic t_freerun();
        write_cfg(8'h21);
        prep(10, 1);
        repeat (10) @(negedge clk);
        check("R6 no auto start", n_starts, 0);
        check("R6 idle", busy, 0);
        pulse_go();
        wait_rdy("R7 first");
        check("R7 first res", res_data, 21);
        pulse_clr();
        wait_rdy("R7 second");
        check("R7 second res", res_data, 25);
        write_cfg(8'h01);
        pulse_clr();
        wait_rdy("R9 tail");
        check("R9 tail res", res_data, 29);
        repeat (20) @(negedge clk);
        check("R9 stopped", busy, 0);
        check("R9 starts", n_starts, 6);
    endtask

    task automatic t_clear();
        // ready is still set from the previous scenario
        check("R10 pre", res_rdy, 1);
        @(negedge clk); res_rd = 1'b1;
        @(negedge clk); res_rd = 1'b0;
        check("R10 read clears", res_rdy, 0);
        write_cfg(8'h00);
        prep(5, 0);
        @(negedge clk); rdy_clr = 1'b1;
        pulse_go();
        wait_rdy("R10 set wins");
        @(negedge clk); rdy_clr = 1'b0;
        check("R10 cleared after", res_rdy, 0);
    endtask

    task automatic t_busy_go();
        write_cfg(8'h01);
        prep(7, 1);
        pulse_go();
        pulse_go();
        pulse_go();
        wait_rdy("R11 busy");
        check("R11 busy res", res_data, 15);
        repeat (10) @(negedge clk);
        check("R11 go ignored", n_starts, 2);
        pulse_clr();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_mask();
        t_single();
        t_accum4();
        t_left_adj();
        t_reserved();
        t_freerun();
        t_clear();
        t_busy_go();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule